// File: doc/BRIEF.md
# Smart Card Character Receiver with Repeat Request

This block takes in characters from a smart card on one shared, open-drain I/O line. It uses asynchronous character framing in the half-duplex, character-oriented protocol style. The block runs on the card clock. A counter splits that clock into elementary time units (ETUs), one ETU per bit. The receiver passes the line through a synchronizer and watches for a falling edge. It confirms the start bit at mid-bit, then collects eight data bits, least significant first, and one parity bit, each sampled at the middle of its ETU.

When the parity check fails, the receiver asks the card to send the character again. One ETU after the parity bit begins (half an ETU after its sample point), it pulls the line low for exactly one ETU, then releases the line and rearms for the repeated start bit. A failed character never reaches the data register and never sets the data-ready flag. It only raises the parity-error flag.

Software sees the receiver through a small register port with a control register, a status register and a data register. Two level interrupt outputs are gated by an interrupt enable and by a control bit that keeps only the error interrupt active.

Top module: `sc_t0_rx`

## Requirements
- R1: A character starts on a falling edge of the synchronized line. The ETU length is a parameter with a default of 372 clocks, counted 0 to 371. The start bit is sampled at count 185 and must still read low there, otherwise the receiver goes back to idle and reports nothing.
- R2: After the start bit come data bits D0 to D7 (D0 first, stored in bit 0 of the data register) and a parity bit. Parity is correct when D0..D7 and the parity bit together hold an even number of ones.
- R3: A character with correct parity loads the data register and sets the full flag (status bit 0). It leaves the parity-error flag unchanged and does not drive the line.
- R4: A character with bad parity sets the parity-error flag (status bit 1). It leaves the full flag and the data register unchanged.
- R5: After a bad-parity character, io_drive_low is high for exactly one ETU, in the ETU that follows the parity bit. It is low in every other window. The receiver then accepts the repeated character.
- R6: irq_err equals parity-error AND receive-interrupt enable (control bit 1). irq_rx equals full AND receive-interrupt enable AND NOT error-only (control bit 2).
- R7: The register map is address 0 for control (bit 0 receiver enable, bit 1 interrupt enable, bit 2 error-only), address 1 for status (bit 0 full, bit 1 parity error, bit 2 overrun) and address 2 for received data. A status flag is cleared by writing 0 to its bit only if a status read returned it as 1 since the last status write. Writing 1 has no effect.
- R8: A good character that completes while full is still set sets the overrun flag (status bit 2). The data register keeps its earlier value.
- R9: While the receiver enable is 0, characters on the line change no flag and no data, and io_drive_low stays low.
- R10: After reset all registers read 0, io_drive_low is low and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, all logic on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_in | input | 1 | Sensed level of the shared I/O line |
| io_drive_low | output | 1 | 1 pulls the shared line low (error signal) |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing on status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq_rx | output | 1 | Receive-data interrupt request (level) |
| irq_err | output | 1 | Parity-error interrupt request (level) |

## Verification
Count from the clock edge that first captures the start-bit low. The two-stage synchronizer puts the ETU counter at 0 two cycles later. The flags and data are updated 3536 cycles after that first edge, at the parity sample point. The error drive runs from cycle 3722 to cycle 4093. The bench therefore checks that the line is not driven 100 cycles into the parity bit. It checks the drive 186 cycles into the error ETU, checks release one full ETU after that window ends, and reads status only after the window. Every sample point sits at least a hundred cycles away from any edge the design can move. Register reads are taken one time step after the address is set, since the read path is combinational.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_BITS   = 2'd1,
        RX_ERRSIG = 2'd2
    } rx_state_e;

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_DATA = 2;

    // control bit positions
    localparam int CB_EN  = 0;
    localparam int CB_RIE = 1;
    localparam int CB_EIO = 2;

    // status bit positions
    localparam int SB_FULL = 0;
    localparam int SB_PERR = 1;
    localparam int SB_OVR  = 2;
    localparam int SB_N    = 3;

endpackage

// File: rtl/sc_t0_sync.sv
module sc_t0_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q, pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign line_o = pipe_q[STAGES-1];
    assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/sc_t0_frame.sv
module sc_t0_frame
    import sc_t0_pkg::*;
#(
    parameter int ETU_CLKS = 372,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line,
    input  logic              fall,
    output logic              good_o,
    output logic              bad_o,
    output logic [DATA_W-1:0] data_o,
    output logic              drive_low_o
);
    localparam int CNT_W = $clog2(ETU_CLKS);
    localparam int BIT_N = DATA_W + 2;
    localparam int IDX_W = $clog2(BIT_N + 1);
    localparam logic [CNT_W-1:0] MID     = CNT_W'(ETU_CLKS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(ETU_CLKS - 1);
    localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(BIT_N - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shr;
        logic              par;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d      = q;
        good_o = 1'b0;
        bad_o  = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (fall) begin
                    d.st  = RX_BITS;
                    d.cnt = '0;
                    d.idx = '0;
                    d.par = 1'b0;
                end
            end
            RX_BITS: begin
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    if (q.idx == PAR_IDX) d.st = q.par ? RX_ERRSIG : RX_IDLE;
                    else                  d.idx = q.idx + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
                if (q.cnt == MID) begin
                    if (q.idx == '0) begin
                        if (line) d.st = RX_IDLE;   // start bit not confirmed
                    end else if (q.idx == PAR_IDX) begin
                        d.par = q.par ^ line;       // 1 marks a parity failure
                        if (q.par ^ line) bad_o  = 1'b1;
                        else              good_o = 1'b1;
                    end else begin
                        d.shr = {line, q.shr[DATA_W-1:1]};
                        d.par = q.par ^ line;
                    end
                end
            end
            RX_ERRSIG: begin
                if (q.cnt == LAST) begin
                    d.st  = RX_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
        if (!en) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
            d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= RX_IDLE;
            q.cnt <= '0;
            q.idx <= '0;
            q.shr <= '0;
            q.par <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o      = q.shr;
    assign drive_low_o = (q.st == RX_ERRSIG);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             par_q;
    logic             in_bits_q;
    assign idx_q     = q.idx;
    assign cnt_q     = q.cnt;
    assign par_q     = q.par;
    assign in_bits_q = (q.st == RX_BITS);

    // R5: the error signal only follows a failed parity bit
    a_r5_err_after_parity: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low_o) |-> ($past(idx_q) == PAR_IDX) && $past(par_q));

    // R5: the error signal ends only after a full ETU
    a_r5_err_one_etu: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_low_o) && $past(en)) |-> ($past(cnt_q) == LAST));

    // R9: disabling releases the line on the next cycle
    a_r9_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !drive_low_o);

    // R1: a character only begins at a detected falling edge
    a_r1_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_bits_q) |-> $past(fall));

endmodule

// File: rtl/sc_t0_regs.sv
module sc_t0_regs
    import sc_t0_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              good_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              en_o,
    output logic              irq_rx_o,
    output logic              irq_err_o
);
    typedef struct packed {
        logic              en;
        logic              rie;
        logic              eio;
        logic              full;
        logic              perr;
        logic              ovr;
        logic [SB_N-1:0]   armed;
        logic [DATA_W-1:0] data;
    } rg_t;

    rg_t q, d;
    logic wr_ctrl, wr_stat, rd_stat;

    assign wr_ctrl = wr_i && (addr_i == ADDR_W'(A_CTRL));
    assign wr_stat = wr_i && (addr_i == ADDR_W'(A_STAT));
    assign rd_stat = rd_i && (addr_i == ADDR_W'(A_STAT));

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.en  = wdata_i[CB_EN];
            d.rie = wdata_i[CB_RIE];
            d.eio = wdata_i[CB_EIO];
        end
        if (wr_stat) begin
            d.full  = q.full & ~(q.armed[SB_FULL] & ~wdata_i[SB_FULL]);
            d.perr  = q.perr & ~(q.armed[SB_PERR] & ~wdata_i[SB_PERR]);
            d.ovr   = q.ovr  & ~(q.armed[SB_OVR]  & ~wdata_i[SB_OVR]);
            d.armed = '0;
        end else if (rd_stat) begin
            d.armed = {q.ovr, q.perr, q.full};
        end
        // receiver events win over a clear in the same cycle
        if (good_i) begin
            if (q.full) d.ovr  = 1'b1;
            else        d.data = rx_data_i;
            d.full = 1'b1;
        end
        if (bad_i) d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(A_CTRL): rdata_o = REG_W'({q.eio, q.rie, q.en});
            ADDR_W'(A_STAT): rdata_o = REG_W'({q.ovr, q.perr, q.full});
            ADDR_W'(A_DATA): rdata_o = REG_W'(q.data);
            default:         rdata_o = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[REG_W-1:SB_N];

    assign en_o      = q.en;
    assign irq_rx_o  = q.full & q.rie & ~q.eio;
    assign irq_err_o = q.perr & q.rie;

    logic full_q, perr_q, ovr_q;
    logic [DATA_W-1:0] data_q;
    assign full_q = q.full;
    assign perr_q = q.perr;
    assign ovr_q  = q.ovr;
    assign data_q = q.data;

    // R3: a good character leaves the full flag set
    a_r3_good_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        good_i |=> full_q);

    // R4: a bad character leaves the parity-error flag set
    a_r4_bad_sets_perr: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> perr_q);

    // R4: a bad character does not touch the data register
    a_r4_bad_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_i && !good_i) |=> $stable(data_q));

    // R8: overrun only arises from a good character landing on a full register
    a_r8_ovr_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(good_i && full_q));

endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx #(
    parameter int ETU_CLKS    = 372,
    parameter int DATA_W      = 8,
    parameter int REG_W       = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_in,
    output logic              io_drive_low,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              line_s, fall_s;
    logic              rx_en, good, bad;
    logic [DATA_W-1:0] rx_data;

    sc_t0_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (io_in),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    sc_t0_frame #(.ETU_CLKS(ETU_CLKS), .DATA_W(DATA_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (rx_en),
        .line        (line_s),
        .fall        (fall_s),
        .good_o      (good),
        .bad_o       (bad),
        .data_o      (rx_data),
        .drive_low_o (io_drive_low)
    );

    sc_t0_regs #(.DATA_W(DATA_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .wdata_i   (reg_wdata),
        .good_i    (good),
        .bad_i     (bad),
        .rx_data_i (rx_data),
        .rdata_o   (reg_rdata),
        .en_o      (rx_en),
        .irq_rx_o  (irq_rx),
        .irq_err_o (irq_err)
    );

endmodule

// File: tb/sim_sc_t0_rx.sv
module sim_sc_t0_rx;
    localparam int ETU = 372;
    localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n, card_line, io_in, drv;
    logic [1:0] reg_addr;
    logic       reg_wr, reg_rd, irq_rx, irq_err;
    logic [7:0] reg_wdata, reg_rdata;

    always #2 clk = ~clk;   // 250 MHz

    assign io_in = card_line & ~drv;

    sc_t0_rx u0 (
        .clk(clk), .rst_n(rst_n), .io_in(io_in), .io_drive_low(drv),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    int   n_chk = 0, n_err = 0;
    logic m_full = 0, m_perr = 0, m_ovr = 0, m_rie = 0, m_eio = 0;
    logic [7:0] m_data = 8'h00;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

    function automatic logic [7:0] exp_status();
        return {5'b0, m_ovr, m_perr, m_full};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        logic [7:0] v;
        rd(AS, v); chk({tag, " R7 status"}, v, exp_status());
        rd(AD, v); chk({tag, " R2 data"}, v, m_data);
        chk({tag, " R6 irq_rx"}, irq_rx, m_full & m_rie & ~m_eio);
        chk({tag, " R6 irq_err"}, irq_err, m_perr & m_rie);
    endtask

    task automatic clear_status();
        logic [7:0] v;
        rd(AS, v);
        wr(AS, 8'h00);
        m_full = 0; m_perr = 0; m_ovr = 0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic corrupt,
                              input logic live, input string tag);
        logic p;
        p = even_par(b) ^ corrupt;
        for (int i = 0; i < 10; i++) begin
            card_line = (i == 0) ? 1'b0 : (i == 9) ? p : b[i-1];
            if (i == 9) begin
                wait_n(100);
                chk({tag, " R5 idle in parity bit"}, drv, 0);
                wait_n(ETU - 100);
            end else begin
                wait_n(ETU);
            end
        end
        card_line = 1'b1;
        wait_n(186);
        chk({tag, " R5 error window"}, drv, corrupt & live);
        wait_n(ETU - 186 + ETU);
        chk({tag, " R5 released"}, drv, 0);
        if (live) begin
            if (corrupt) m_perr = 1;
            else begin
                if (m_full) m_ovr = 1;
                else        m_data = b;
                m_full = 1;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        logic       bad;
        int         seed;
        rst_n = 0; card_line = 1; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
        wait_n(5);
        rst_n = 1;
        wait_n(2);

        // R10 reset state
        chk("R10 drive", drv, 0);
        chk("R10 irq", {irq_rx, irq_err}, 0);
        rd(AC, v); chk("R10 ctrl", v, 0);
        rd(AS, v); chk("R10 status", v, 0);
        rd(AD, v); chk("R10 data", v, 0);

        wr(AC, 8'h03); m_rie = 1;

        // R3 good character
        send_frame(8'hA5, 0, 1, "good A5 R3");
        check_regs("after A5 R3");

        // R7 clear rules
        wr(AS, 8'hFF);                  // ones: no effect, disarms
        wr(AS, 8'h00);                  // not armed: no effect
        rd(AS, v); chk("R7 unarmed write keeps flags", v, exp_status());
        wr(AS, 8'h00);                  // armed by the read above
        m_full = 0;
        check_regs("R7 after clear");

        // R4/R5 bad character, then its repeat
        send_frame(8'h3C, 1, 1, "bad 3C R4");
        check_regs("after bad R4");
        send_frame(8'h3C, 0, 1, "repeat 3C R3");
        check_regs("after repeat R3 perr kept");
        clear_status();

        // R8 overrun
        send_frame(8'h5A, 0, 1, "5A");
        send_frame(8'hC3, 0, 1, "C3 R8");
        check_regs("R8 overrun");

        // R6 error-only mode
        wr(AC, 8'h07); m_eio = 1;
        check_regs("R6 eio");
        clear_status();
        wr(AC, 8'h03); m_eio = 0;

        // R1 false start shorter than half an ETU
        card_line = 0; wait_n(60); card_line = 1;
        wait_n(2 * ETU);
        chk("R1 glitch no drive", drv, 0);
        check_regs("R1 glitch ignored");
        send_frame(8'h96, 0, 1, "R1 after glitch");
        check_regs("R1 after glitch");
        clear_status();

        // R9 disabled receiver
        wr(AC, 8'h02);
        send_frame(8'hE7, 1, 0, "R9 disabled");
        check_regs("R9 disabled");
        wr(AC, 8'h03);

        // random characters, some corrupted then repeated
        seed = $urandom(32'h5EED);
        for (int k = 0; k < 8; k++) begin
            b   = 8'($urandom);
            bad = (($urandom % 3) == 0);
            clear_status();
            if (bad) begin
                send_frame(b, 1, 1, "rand bad R4");
                check_regs("rand bad R4");
            end
            send_frame(b, 0, 1, "rand good R2");
            check_regs("rand good R2");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule